// File: doc/BRIEF.md
# Configurable UART frame transmitter

This block turns one parallel byte into an asynchronous serial frame on a single transmit line. The frame layout is set separately for every frame by a small control word. That word picks the number of data bits (5 to 8), one or two stop bits, and whether a parity bit is sent and whether it is even or odd. An external divider supplies a one-cycle baud-tick enable. The block counts a fixed number of these ticks for every bit it sends.

A producer offers a byte with a valid/ready handshake. The byte is taken only while the transmitter is idle. The data and the control word are captured at that moment, so later changes on those inputs do not disturb a frame in flight. The state machine steps through six named states:

- `ST_IDLE` (line high, ready).
- `ST_START` (line low).
- `ST_DATA` (data bits, least significant first).
- `ST_PARITY`.
- `ST_STOP1`.
- `ST_STOP2`.

Its transitions are:

- accept: `ST_IDLE` to `ST_START`
- start done: `ST_START` to `ST_DATA`
- last data bit with parity on: `ST_DATA` to `ST_PARITY`
- last data bit with parity off: `ST_DATA` to `ST_STOP1`
- parity done: `ST_PARITY` to `ST_STOP1`
- first stop with two stops: `ST_STOP1` to `ST_STOP2`
- first stop with one stop: `ST_STOP1` to `ST_IDLE`
- second stop done: `ST_STOP2` to `ST_IDLE`

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `tx` is 1, `busy` is 0 and `in_ready` is 1. While a frame is in progress, `busy` is 1 and `in_ready` is 0.
- R2: A byte is accepted at a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `busy` is 1 and `tx` carries the start bit, 0.
- R3: Every bit of a frame lasts exactly TICKS_PER_BIT baud ticks (default 16). `tx` changes only at the edge that samples the last tick of a bit. `busy` falls at the edge that samples the last tick of the final stop bit.
- R4: `ctrl[1:0]` selects the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits follow the start bit, least significant first.
- R5: `ctrl[2]` selects the stop bits, which are driven high: 0 gives one stop bit and 1 gives two.
- R6: `ctrl[3]` = 1 inserts a parity bit after the last data bit. With `ctrl[4]` = 1 the parity is even: the count of ones over the active data bits plus the parity bit is even. With `ctrl[4]` = 0 that count is odd. Data bits beyond the selected length have no effect on parity.
- R7: A control value of 0x03 gives a 10-bit frame: a start bit, 8 data bits and one stop bit, with no parity bit.
- R8: Changes on `in_data`, `ctrl` and `in_valid` while a frame is in progress do not change that frame.
- R9: Baud ticks while idle start no frame and leave `tx` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Transmitter idle, byte can be taken |
| in_data | input | 8 | Byte to send |
| ctrl | input | 5 | Frame format: [1:0] length, [2] stop count, [3] parity enable, [4] even parity |
| baud_tick | input | 1 | One-cycle bit-timing enable |
| tx | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |

## Verification
The handshake result is due one cycle after the accepting edge: `busy` is 1 and `tx` is 0. Each later bit appears in the cycle after the edge that samples the TICKS_PER_BIT-th tick of the previous bit. The bench drives every input at the falling edge and drives each tick itself. It can therefore sample `tx` at a falling edge just before the first and the last tick of every bit. It checks `busy`, `in_ready` and `tx` after the final tick of a frame. Random frames mix all 32 control values with random tick gaps. Inputs are scrambled during each frame to show that the latched values are the ones that govern it.

// File: rtl/uft_pkg.sv
package uft_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } uft_state_e;

    // Control word layout; field order is what the port decodes.
    typedef struct packed {
        logic       par_even;
        logic       par_en;
        logic       two_stop;
        logic [1:0] wlen;
    } uft_ctrl_t;
endpackage

// File: rtl/uft_bit_timer.sv
module uft_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic bit_done
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign bit_done = tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= bit_done ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uft_parity.sv
module uft_parity #(
    parameter int DATA_W = 8,
    parameter int WLEN_W = 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [WLEN_W-1:0] wlen,
    input  logic              even,
    output logic              par
);
    localparam int MIN_W = DATA_W - (2 ** WLEN_W) + 1;

    logic [DATA_W-1:0] mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (i < MIN_W) || (int'(wlen) > i - MIN_W);
    end

    assign par = even ? ^(data & mask) : ~^(data & mask);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uft_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [4:0]        ctrl,
    input  logic              baud_tick,
    output logic              tx,
    output logic              busy
);
    localparam int WLEN_W = 2;
    localparam int MIN_W  = DATA_W - (2 ** WLEN_W) + 1;
    localparam int IDX_W  = $clog2(DATA_W);

    uft_state_e        state, state_nx;
    logic [DATA_W-1:0] data_q;
    uft_ctrl_t         cfg_q;
    logic [IDX_W-1:0]  bit_idx;
    logic              bit_done;
    logic              par_bit;
    logic              accept;
    logic              last_data;

    assign accept    = in_valid && (state == ST_IDLE);
    assign last_data = (int'(bit_idx) == MIN_W - 1 + int'(cfg_q.wlen));

    uft_bit_timer #(.TICKS(TICKS_PER_BIT)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state == ST_IDLE),
        .tick     (baud_tick),
        .bit_done (bit_done)
    );

    uft_parity #(.DATA_W(DATA_W), .WLEN_W(WLEN_W)) i_parity (
        .data (data_q),
        .wlen (cfg_q.wlen),
        .even (cfg_q.par_even),
        .par  (par_bit)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_START;
            ST_START:  if (bit_done) state_nx = ST_DATA;
            ST_DATA:   if (bit_done && last_data)
                           state_nx = cfg_q.par_en ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_done) state_nx = ST_STOP1;
            ST_STOP1:  if (bit_done)
                           state_nx = cfg_q.two_stop ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Frame capture and bit index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            cfg_q   <= '0;
            bit_idx <= '0;
        end else begin
            if (accept) begin
                data_q  <= in_data;
                cfg_q   <= uft_ctrl_t'(ctrl);
                bit_idx <= '0;
            end else if (state == ST_DATA && bit_done) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        tx       = 1'b1;
        busy     = 1'b1;
        in_ready = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                in_ready = 1'b1;
            end
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = data_q[bit_idx];
            ST_PARITY: tx = par_bit;
            ST_STOP1,
            ST_STOP2:  tx = 1'b1;
            default:   tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/uft_tx_checker.sv
module uft_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic baud_tick,
    input logic tx,
    input logic busy
);
    // R1: the line is high whenever no frame is running
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    // R1: ready and busy are complements
    a_r1_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready != busy);

    // R2: a handshake starts a frame in the next cycle
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    // R2: a frame opens with a low start bit
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx);

    // R3: within a frame the line moves only on a tick
    a_r3_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |=> $stable(tx) && busy);

    // R9: ticks while idle start nothing
    a_r9_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !in_valid) |=> !busy);
endmodule

bind uart_frame_tx uft_tx_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .baud_tick (baud_tick),
    .tx        (tx),
    .busy      (busy)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic [4:0] ctrl = '0;
    logic       baud_tick = 1'b0;
    logic       tx;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_frame_tx #(.DATA_W(8), .TICKS_PER_BIT(TPB)) i_uart_frame_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .ctrl      (ctrl),
        .baud_tick (baud_tick),
        .tx        (tx),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int dlen(input logic [4:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic int nbits(input logic [4:0] c);
        return 1 + dlen(c) + int'(c[3]) + 1 + int'(c[2]);
    endfunction

    function automatic logic exp_bit(input logic [7:0] d, input logic [4:0] c, input int i);
        int  n = dlen(c);
        logic p = 1'b0;
        for (int j = 0; j < n; j++) p ^= d[j];
        if (i == 0) return 1'b0;
        if (i <= n) return d[i-1];
        if (c[3] && i == n + 1) return c[4] ? p : ~p;
        return 1'b1;
    endfunction

    function automatic string bit_tag(input logic [4:0] c, input int i, input string ovr);
        if (ovr != "") return ovr;
        if (i == 0) return "R2";
        if (i <= dlen(c)) return "R4";
        if (c[3] && i == dlen(c) + 1) return "R6";
        return "R5";
    endfunction

    task automatic do_tick();
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [4:0] c,
                             input string ovr, input bit scramble);
        int n = nbits(c);
        chk(in_ready === 1'b1, "R1", int'(in_ready), 1);
        in_valid = 1'b1;
        in_data  = d;
        ctrl     = c;
        @(negedge clk);
        in_valid = 1'b0;
        if (scramble) begin
            in_data = 8'($urandom);
            ctrl    = 5'($urandom);
        end
        chk(busy === 1'b1, "R2", int'(busy), 1);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < TPB; k++) begin
                if (k == 0 || k == TPB - 1)
                    chk(tx === exp_bit(d, c, i), (k == 0) ? bit_tag(c, i, ovr) : "R3",
                        int'(tx), int'(exp_bit(d, c, i)));
                if (k == 0) begin
                    if (scramble && i < n - 1) begin
                        in_valid = 1'($urandom);
                        in_data  = 8'($urandom);
                        ctrl     = 5'($urandom);
                    end else begin
                        in_valid = 1'b0;
                    end
                    if (i == 1) chk(in_ready === 1'b0, "R8", int'(in_ready), 0);
                end
                do_tick();
            end
        end
        chk(busy === 1'b0, "R3", int'(busy), 0);
        chk(tx === 1'b1, "R1", int'(tx), 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx === 1'b1, "R1", int'(tx), 1);
        chk(busy === 1'b0, "R1", int'(busy), 0);
        chk(in_ready === 1'b1, "R1", int'(in_ready), 1);

        // R9: idle ticks
        for (int i = 0; i < 20; i++) begin
            do_tick();
            chk(tx === 1'b1 && busy === 1'b0, "R9", int'(tx), 1);
        end

        // R7: 8N1
        run_frame(8'hA5, 5'h03, "R7", 1'b0);
        run_frame(8'h3C, 5'h03, "R7", 1'b1);
        // R4: each length, high bits set beyond length
        for (int w = 0; w < 4; w++) run_frame(8'hE6, 5'(w), "", 1'b1);
        // R5: two stop bits
        run_frame(8'h81, 5'b00111, "", 1'b0);
        // R6: even/odd parity with ignored upper bits
        run_frame(8'hE0, 5'b11000, "", 1'b1);
        run_frame(8'hE0, 5'b01000, "", 1'b1);
        run_frame(8'h1F, 5'b11000, "", 1'b1);
        run_frame(8'h7F, 5'b01011, "", 1'b0);
        run_frame(8'hFF, 5'b11111, "", 1'b1);
        // R8: random frames with scrambled inputs
        for (int f = 0; f < 24; f++)
            run_frame(8'($urandom), 5'($urandom), "", 1'b1);
        summary();
    end
endmodule